// File: doc/BRIEF.md
# Running CRC-32 Accumulator

This block folds a stream of 32-bit words into a 32-bit cyclic redundancy check. The generator polynomial is fixed at 0x04C11DB7. Each word is consumed most significant bit first, and the whole word is folded in a single clock cycle. The block serves two purposes. A sender uses it to produce a check value and appends that value to a frame. A receiver uses it to recompute the check value and compares the result with the one it received.

Each frame starts with a synchronous frame restart. The restart loads the accumulator with a seed taken from an input port. Ethernet-like and PCI Express-like links use the all-ones seed. One serial storage link uses the seed 0x52325032. After the restart is released, the output reads zero for exactly one cycle. From the next cycle on, the output shows the accumulated value. That value is the raw register, with no final inversion and no bit reflection.

Top module: `crc32_acc`

## Requirements
- R1: While `rst_n` is low, `crc_out` reads 0. After `rst_n` rises, the accumulator holds the parameter default 0xFFFFFFFF until a frame restart or a valid word arrives.
- R2: A clock edge with `frame_rst` high loads the accumulator with `seed`. `crc_out` reads 0 on the cycle after every such edge.
- R3: On the first cycle after `frame_rst` goes low, `crc_out` reads 0x00000000, even when a word is accepted on that cycle. From the following cycle on, `crc_out` equals the accumulator.
- R4: A clock edge with `frame_rst` low and `din_vld` high folds `din` into the accumulator. Bit 31 of `din` is folded first. The feedback rule is: feedback = accumulator bit 31 XOR data bit; the accumulator shifts left by one; 0x04C11DB7 is XORed in when the feedback is 1. The new value appears on `crc_out` one cycle later. For example, seed 0 followed by the word 0x00000001 gives 0x04C11DB7.
- R5: The accumulation carries across words. Each accepted word updates the previous result, until the next frame restart.
- R6: A clock edge with `frame_rst` low and `din_vld` low leaves the accumulator and `crc_out` unchanged.
- R7: The seed 0x52325032 gives the same result as the bit-serial definition in R4, applied from that seed.
- R8: When `frame_rst` and `din_vld` are both high at a clock edge, the word is dropped. The accumulator holds exactly `seed` afterwards.
- R9: `crc_out` is the raw accumulator, with no final XOR and no bit reversal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| frame_rst | input | 1 | Synchronous frame restart, active high; loads the seed |
| seed | input | 32 | Starting value loaded on frame restart |
| din | input | 32 | Data word |
| din_vld | input | 1 | Data word is valid this cycle |
| crc_out | output | 32 | Accumulated check value (zero during the restart window) |

## Verification
The frame restart and a valid data word can arrive on the same edge. The restart must win, and the word must be lost. The random stimulus raises both signals together on a share of cycles, and the directed part also forces this case. The bench then feeds known words after the restart. It compares each result with a bit-serial model that was loaded with the seed alone, so a word that leaked into the accumulator shows up as a mismatch.

// File: rtl/crc32_acc.sv
module crc32_acc #(
  parameter int              DW      = 32,
  parameter int              CW      = 32,
  parameter logic [CW-1:0]   POLY    = 32'h04C11DB7,
  parameter logic [CW-1:0]   RST_VAL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_rst,
  input  logic [CW-1:0] seed,
  input  logic [DW-1:0] din,
  input  logic          din_vld,
  output logic [CW-1:0] crc_out
);

  localparam int TOP = CW - 1;

  function automatic logic [CW-1:0] fold(input logic [CW-1:0] c_in, input logic [DW-1:0] d);
    logic [CW-1:0] c;
    logic          fb;
    c = c_in;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = c[TOP] ^ d[i];
      c  = {c[TOP-1:0], 1'b0} ^ ({CW{fb}} & POLY);
    end
    return c;
  endfunction

  logic [CW-1:0] crc_q;
  logic          blank_q;
  logic [CW-1:0] crc_nxt;

  assign crc_nxt = fold(crc_q, din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q   <= RST_VAL;
      blank_q <= 1'b1;
    end else if (frame_rst) begin
      crc_q   <= seed;
      blank_q <= 1'b1;
    end else begin
      blank_q <= 1'b0;
      if (din_vld) crc_q <= crc_nxt;
    end
  end

  assign crc_out = blank_q ? '0 : crc_q;

endmodule

// File: rtl/crc32_acc_chk.sv
module crc32_acc_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_rst,
  input logic          din_vld,
  input logic [CW-1:0] seed,
  input logic [CW-1:0] crc_q,
  input logic [CW-1:0] crc_out
);

  p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rst |=> crc_q == $past(seed));

  p_blank_after_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rst |=> crc_out == '0);

  p_raw_output_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_rst |=> crc_out == crc_q);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_rst && !din_vld) |=> $stable(crc_q));

  p_restart_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_rst && din_vld) |=> crc_q == $past(seed));

  always_comb begin
    if (!rst_n) a_reset_zero_r1: assert (crc_out == '0);
  end

endmodule

bind crc32_acc crc32_acc_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frame_rst(frame_rst),
  .din_vld  (din_vld),
  .seed     (seed),
  .crc_q    (crc_q),
  .crc_out  (crc_out)
);

// File: tb/test_crc32_acc.sv
`timescale 1ns/1ps
module test_crc32_acc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_rst = 1'b0;
  logic [31:0] seed = '0;
  logic [31:0] din = '0;
  logic        din_vld = 1'b0;
  logic [31:0] crc_out;

  int total = 0;
  int bad   = 0;

  logic [31:0] model;
  logic        blank;

  always #4 clk = ~clk;

  crc32_acc i_crc32_acc (
    .clk(clk), .rst_n(rst_n), .frame_rst(frame_rst), .seed(seed),
    .din(din), .din_vld(din_vld), .crc_out(crc_out)
  );

  function automatic logic [31:0] ref_step(input logic [31:0] r, input logic [31:0] w);
    logic [31:0] acc;
    logic        bit_in;
    logic        out_bit;
    acc = r;
    for (int k = 0; k < 32; k++) begin
      bit_in  = w[31-k];
      out_bit = acc[31];
      acc     = acc << 1;
      if (out_bit != bit_in) acc = acc ^ 32'h04C11DB7;
    end
    return acc;
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    total++;
    if (crc_out !== exp) begin
      bad++;
      $display("FAIL %s: crc_out=%h expected=%h", tag, crc_out, exp);
    end
  endtask

  task automatic cyc(input logic fr, input logic v, input logic [31:0] d, input string tag);
    frame_rst = fr; din_vld = v; din = d;
    @(posedge clk);
    if (fr) begin
      model = seed; blank = 1'b1;
    end else begin
      blank = 1'b0;
      if (v) model = ref_step(model, d);
    end
    @(negedge clk);
    check(tag, blank ? 32'h0 : model);
  endtask

  function automatic string auto_tag(input logic fr, input logic v);
    if (fr && v) return "R8";
    if (fr) return "R2";
    if (blank) return "R3";
    if (v) return "R5";
    return "R6";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: crc_out=%h expected=completion", crc_out);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic fr, v;
    void'($urandom(32'd20240611));
    model = 32'hFFFFFFFF; blank = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 32'h0, "R1 first idle");
    cyc(1'b0, 1'b1, 32'h12345678, "R1 default seed");
    check("R1 default seed", ref_step(32'hFFFFFFFF, 32'h12345678));

    seed = 32'h0;
    cyc(1'b1, 1'b0, 32'h0, "R2 load zero seed");
    cyc(1'b0, 1'b1, 32'h00000001, "R3 blank with word");
    cyc(1'b0, 1'b0, 32'h0, "R4 single word");
    check("R4 known value", 32'h04C11DB7);
    check("R9 raw output", model);

    cyc(1'b0, 1'b1, 32'hDEADBEEF, "R5 word two");
    cyc(1'b0, 1'b1, 32'hCAFEF00D, "R5 word three");
    cyc(1'b0, 1'b0, 32'h0, "R6 hold");
    cyc(1'b0, 1'b0, 32'hFFFFFFFF, "R6 hold ignores din");

    seed = 32'h52325032;
    cyc(1'b1, 1'b0, 32'h0, "R7 storage seed load");
    cyc(1'b0, 1'b1, 32'hA5A5A5A5, "R7 blank cycle");
    cyc(1'b0, 1'b1, 32'h0F0F0F0F, "R7 storage seed");
    check("R7 storage seed value",
          ref_step(ref_step(32'h52325032, 32'hA5A5A5A5), 32'h0F0F0F0F));

    seed = 32'hFFFFFFFF;
    cyc(1'b1, 1'b1, 32'h11111111, "R8 restart with word");
    cyc(1'b1, 1'b1, 32'h22222222, "R8 held restart with word");
    cyc(1'b0, 1'b0, 32'h0, "R3 blank idle");
    cyc(1'b0, 1'b1, 32'h33333333, "R8 word after restart");
    check("R8 seed only", ref_step(32'hFFFFFFFF, 32'h33333333));

    for (int n = 0; n < 3000; n++) begin
      fr = ($urandom % 16) == 0;
      v  = ($urandom % 4) != 0;
      if (fr && ($urandom % 2)) seed = $urandom;
      cyc(fr, v, $urandom, auto_tag(fr, v));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule